// File: doc/BRIEF.md
# Prioritised Three-Source Video Selector

This block routes one of three parallel video-and-audio source ports onto a single output port. Each port is 23 signals wide: eight luma bits, eight chroma bits, the horizontal and vertical timing references, the pixel clock and the four audio serial lines. Sources A and B are offered through a shared pair of inputs: an activity flag saying that one of the two is live, and a pick line that chooses between them. Source C has a valid flag of its own. The routing is purely combinational. All 23 output signals follow one select decision, with no register in the data path.

Two configuration choices come from the activity and pick lines. The block samples them on every clock edge while reset is held low. The value taken at the last edge before reset is released stays fixed until the next reset. After release, the same lines act only as live routing inputs. One strap sets the idle output. When it is high, the idle output is undriven. When it is low, the idle output is driven to all zeros. The other strap sets which side wins when A/B and C are valid at the same time. High-impedance pads are modelled as a per-signal drive-enable vector alongside the data. A status output is high whenever a source is actually being driven onto the output.

Top module: `zvsel_top`

## Requirements
- R1: With ab_active=1, ab_pick=1 selects source A and ab_pick=0 selects source B, provided C does not win. All 23 bits of zv_data then equal the chosen source in the same cycle, and zv_drive is all ones.
- R2: With c_valid=1 and ab_active=0, source C is routed to zv_data.
- R3: When ab_active=1 and c_valid=1 and the precedence strap captured from ab_pick during reset is 0, the A/B source chosen by ab_pick is routed.
- R4: When ab_active=1 and c_valid=1 and the precedence strap is 1, source C is routed.
- R5: When ab_active=0 and c_valid=0, the output is in its idle state and zv_live is 0.
- R6: When out_en_n=1, the output is in its idle state and zv_live is 0, whatever the other inputs are.
- R7: The idle state depends on the strap captured from ab_active during reset. If it is 1, zv_drive is all zeros. If it is 0, zv_drive is all ones and zv_data is all zeros. In both cases zv_data is 0.
- R8: While rst_n=0, zv_drive is all zeros, zv_data is all zeros and zv_live is 0, whatever the other inputs are.
- R9: Both straps take the values of ab_active and ab_pick at the last rising clk edge with rst_n=0. They do not change until the next reset, whatever ab_active and ab_pick do later.
- R10: zv_live is 1 exactly when a source is being routed. Whenever zv_live is 1, zv_drive is all ones.
- R11: When ab_active=0, ab_pick has no effect on routing. In that case only C or the idle state can appear on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the straps during reset |
| rst_n | input | 1 | Active-low reset; outputs quiet, straps sampled while low |
| src_a | input | 23 | Source A signals |
| src_b | input | 23 | Source B signals |
| src_c | input | 23 | Source C signals |
| ab_active | input | 1 | A/B source live; idle-mode strap during reset |
| ab_pick | input | 1 | 1 picks A, 0 picks B; precedence strap during reset |
| c_valid | input | 1 | Source C valid |
| out_en_n | input | 1 | Active-low output enable |
| zv_data | output | 23 | Routed output value |
| zv_drive | output | 23 | Per-signal drive enable (0 = high impedance) |
| zv_live | output | 1 | High while a source is driven onto the output |

## Verification
One vector table covers every combination of the activity, pick, C-valid and enable lines that matters. It is replayed under all four strap settings. Each vector pairs opposite precedence results with distinct bit patterns on the three sources, so that a crossed mux leg, a wrong winner or a partial-width switch shows up as a wrong value. Entries that toggle ab_pick while ab_active is low show that the pick line is ignored in that case. Idle entries under both idle straps tell the undriven idle state apart from the driven-low one. Directed steps hold reset with all sources live to check that the output stays quiet. After release, they move the strap lines and recheck idle mode and precedence to show the captured values hold.

// File: rtl/zvsel_pkg.sv
package zvsel_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_C    = 2'd3
  } src_e;

  // Winner decision for one set of control inputs.
  function automatic src_e pick_source(
    input logic ab_active,
    input logic ab_pick,
    input logic c_valid,
    input logic out_en_n,
    input logic c_first
  );
    src_e ab_side;
    ab_side = ab_pick ? SRC_A : SRC_B;
    if (out_en_n)                    return SRC_NONE;
    else if (ab_active && c_valid)   return c_first ? SRC_C : ab_side;
    else if (ab_active)              return ab_side;
    else if (c_valid)                return SRC_C;
    else                             return SRC_NONE;
  endfunction

endpackage

// File: rtl/zvsel_strap.sv
module zvsel_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_idle_in,
  input  logic strap_prec_in,
  output logic idle_float,
  output logic c_first
);

  // Sampled on every edge while reset is low; frozen once it is released.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_float <= strap_idle_in;
      c_first    <= strap_prec_in;
    end
  end

endmodule

// File: rtl/zvsel_arbiter.sv
module zvsel_arbiter
  import zvsel_pkg::*;
(
  input  logic ab_active,
  input  logic ab_pick,
  input  logic c_valid,
  input  logic out_en_n,
  input  logic c_first,
  output src_e sel,
  output logic sel_live
);

  always_comb begin
    sel      = pick_source(ab_active, ab_pick, c_valid, out_en_n, c_first);
    sel_live = (sel != SRC_NONE);
  end

endmodule

// File: rtl/zvsel_route.sv
module zvsel_route
  import zvsel_pkg::*;
#(
  parameter int BUS_W = 23
) (
  input  src_e             sel,
  input  logic [BUS_W-1:0] src_a,
  input  logic [BUS_W-1:0] src_b,
  input  logic [BUS_W-1:0] src_c,
  output logic [BUS_W-1:0] routed
);

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        SRC_A:   routed[i] = src_a[i];
        SRC_B:   routed[i] = src_b[i];
        SRC_C:   routed[i] = src_c[i];
        default: routed[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/zvsel_top.sv
module zvsel_top
  import zvsel_pkg::*;
#(
  parameter int BUS_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] src_a,
  input  logic [BUS_W-1:0] src_b,
  input  logic [BUS_W-1:0] src_c,
  input  logic             ab_active,
  input  logic             ab_pick,
  input  logic             c_valid,
  input  logic             out_en_n,
  output logic [BUS_W-1:0] zv_data,
  output logic [BUS_W-1:0] zv_drive,
  output logic             zv_live
);

  logic             strap_float;
  logic             strap_cfirst;
  src_e             sel;
  logic             sel_live;
  logic [BUS_W-1:0] routed;
  logic             drive_now;

  zvsel_strap u_strap (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_idle_in (ab_active),
    .strap_prec_in (ab_pick),
    .idle_float    (strap_float),
    .c_first       (strap_cfirst)
  );

  zvsel_arbiter u_arb (
    .ab_active (ab_active),
    .ab_pick   (ab_pick),
    .c_valid   (c_valid),
    .out_en_n  (out_en_n),
    .c_first   (strap_cfirst),
    .sel       (sel),
    .sel_live  (sel_live)
  );

  zvsel_route #(.BUS_W(BUS_W)) u_route (
    .sel    (sel),
    .src_a  (src_a),
    .src_b  (src_b),
    .src_c  (src_c),
    .routed (routed)
  );

  assign drive_now = rst_n & sel_live;

  always_comb begin
    zv_live = drive_now;
    zv_data = drive_now ? routed : '0;
    if (!rst_n)
      zv_drive = '0;
    else if (sel_live)
      zv_drive = '1;
    else
      zv_drive = {BUS_W{~strap_float}};
  end

endmodule

// File: rtl/zvsel_chk.sv
module zvsel_chk #(
  parameter int BUS_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] src_a,
  input logic [BUS_W-1:0] src_b,
  input logic [BUS_W-1:0] src_c,
  input logic             ab_active,
  input logic             ab_pick,
  input logic             c_valid,
  input logic             out_en_n,
  input logic [BUS_W-1:0] zv_data,
  input logic [BUS_W-1:0] zv_drive,
  input logic             zv_live,
  input logic             strap_float,
  input logic             strap_cfirst
);

  // R1
  a_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en_n && ab_active && ab_pick && !(c_valid && strap_cfirst))
      |-> (zv_live && zv_data == src_a));

  // R2
  c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en_n && !ab_active && c_valid) |-> (zv_live && zv_data == src_c));

  // R3
  ab_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en_n && ab_active && !ab_pick && c_valid && !strap_cfirst)
      |-> (zv_data == src_b));

  // R4
  c_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en_n && ab_active && c_valid && strap_cfirst) |-> (zv_data == src_c));

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!zv_live && zv_data == '0));

  // R7
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zv_live && strap_float) |-> (zv_drive == '0));

  // R10
  live_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zv_live |-> (&zv_drive));

  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(strap_float) && $stable(strap_cfirst)));

  // R8
  always @(posedge clk) begin
    if (!rst_n)
      rst_quiet_chk: assert (zv_drive == '0 && zv_data == '0 && !zv_live);
  end

endmodule

bind zvsel_top zvsel_chk #(.BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_a        (src_a),
  .src_b        (src_b),
  .src_c        (src_c),
  .ab_active    (ab_active),
  .ab_pick      (ab_pick),
  .c_valid      (c_valid),
  .out_en_n     (out_en_n),
  .zv_data      (zv_data),
  .zv_drive     (zv_drive),
  .zv_live      (zv_live),
  .strap_float  (strap_float),
  .strap_cfirst (strap_cfirst)
);

// File: tb/tb_zvsel_top.sv
`timescale 1ns/100ps
module tb_zvsel_top;

  localparam int W = 23;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] src_a = '0, src_b = '0, src_c = '0;
  logic         ab_active = 1'b0, ab_pick = 1'b0, c_valid = 1'b0, out_en_n = 1'b1;
  logic [W-1:0] zv_data, zv_drive;
  logic         zv_live;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zvsel_top #(.BUS_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .ab_active(ab_active), .ab_pick(ab_pick), .c_valid(c_valid),
    .out_en_n(out_en_n), .zv_data(zv_data), .zv_drive(zv_drive), .zv_live(zv_live)
  );

  // Entry: {req[3:0], act, pick, cvalid, oe_n, exp_prec_ab[1:0], exp_prec_c[1:0]}
  // Source code: 0 idle, 1 A, 2 B, 3 C.
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    {4'd1,  4'b1100, 2'd1, 2'd1},  // R1 A picked
    {4'd1,  4'b1000, 2'd2, 2'd2},  // R1 B picked
    {4'd2,  4'b0010, 2'd3, 2'd3},  // R2 C alone
    {4'd11, 4'b0110, 2'd3, 2'd3},  // R11 pick ignored
    {4'd3,  4'b1110, 2'd1, 2'd3},  // R3/R4 A vs C
    {4'd4,  4'b1010, 2'd2, 2'd3},  // R4/R3 B vs C
    {4'd5,  4'b0000, 2'd0, 2'd0},  // R5 nothing valid
    {4'd11, 4'b0100, 2'd0, 2'd0},  // R11 pick alone
    {4'd6,  4'b1101, 2'd0, 2'd0},  // R6 disabled
    {4'd6,  4'b0011, 2'd0, 2'd0},  // R6 disabled
    {4'd6,  4'b1111, 2'd0, 2'd0}   // R6 disabled
  };

  task automatic check(input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic expect_out(input string tag, input int s, input bit flt);
    logic [W-1:0] ed;
    logic [W-1:0] edr;
    case (s)
      1: ed = src_a;
      2: ed = src_b;
      3: ed = src_c;
      default: ed = '0;
    endcase
    edr = (s != 0) ? ONES : (flt ? '0 : ONES);
    check({tag, " data"},  zv_data,  ed);
    check({tag, " drive"}, zv_drive, edr);
    check({tag, " live"},  {22'd0, zv_live}, {22'd0, (s != 0)});
  endtask

  task automatic do_reset(input bit flt, input bit cf);
    @(negedge clk);
    rst_n = 1'b0; ab_active = flt; ab_pick = cf;
    c_valid = 1'b1; out_en_n = 1'b0;
    src_a = 23'h1ABCDE; src_b = 23'h2468AC; src_c = 23'h13579B;
    repeat (3) @(posedge clk);
    #1;
    // R8 outputs quiet during reset
    check("R8 reset data",  zv_data,  '0);
    check("R8 reset drive", zv_drive, '0);
    check("R8 reset live",  {22'd0, zv_live}, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(input bit a, input bit p, input bit cv, input bit oen, input int idx);
    @(negedge clk);
    ab_active = a; ab_pick = p; c_valid = cv; out_en_n = oen;
    src_a = 23'h155AA3 + W'(idx) * 23'h01111;
    src_b = ~src_a;
    src_c = src_a ^ 23'h7F00FF;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit flt = cfg[1];
      bit cf  = cfg[0];
      do_reset(flt, cf);
      for (int i = 0; i < NV; i++) begin
        logic [11:0] v = VEC[i];
        int es = cf ? int'(v[1:0]) : int'(v[3:2]);
        apply(v[7], v[6], v[5], v[4], i + cfg * 16);
        // R7 idle mode and R10 drive/live relation checked alongside each entry
        expect_out($sformatf("table[%0d] cfg%0d R%0d", i, cfg, v[11:8]), es, flt);
      end
    end

    // R9: straps float=1, C first; then move the strap lines after release
    do_reset(1'b1, 1'b1);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 40);
    expect_out("R9 idle float held", 0, 1'b1);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 41);
    expect_out("R9 C precedence held", 3, 1'b1);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 42);
    expect_out("R9 idle float after toggles", 0, 1'b1);

    // R9: straps float=0, A/B first
    do_reset(1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 43);
    expect_out("R9 A/B precedence held", 1, 1'b0);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 44);
    expect_out("R7 R9 idle driven low held", 0, 1'b0);

    // R8: reset reasserted mid-run with a live source
    apply(1'b1, 1'b0, 1'b0, 1'b0, 45);
    expect_out("R1 B before reset", 2, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 reassert drive", zv_drive, '0);
    check("R8 reassert data",  zv_data,  '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule